// File: doc/BRIEF.md
# Glitch-Free System Clock Source Selector

This block picks the system clock from one of three sources: a slow, always-available RC clock, a faster internal oscillator whose output is turned on by a frequency-select field, and a primary oscillator that may be followed by a PLL. Software writes a small configuration word that holds a run-mode field, the internal-oscillator frequency field, an internal-source request bit, an idle-enable bit and a PLL enable. The block works out which source that word asks for. It turns the source on and waits until the source is proven stable. Only then does it move the system clock across.

Stability is judged by counters. The internal oscillator gets a fixed settling count. The primary oscillator needs a start-up count of its own cycles, plus a lock interval when the PLL is enabled. During the whole wait the system clock keeps running from whatever source is live. The handover is break-before-make: each source has a short synchroniser chain clocked on the falling edge of that source. The old source is gated off before the new one is gated on, so the output never carries a shortened pulse. Two status flags report whether the internal oscillator is stable and whether the primary oscillator is the live source.

Top module: `clk_src_switch`

## Requirements
- R1: After reset, liveSrc is 0, intStable and ostDone are 0, rdMode is 2'b00 and rdIdle is 0. A configuration word is stored on a rising lfClk edge with wrEn high.
- R2: The target source follows the stored word. Mode bit 1 clear selects the primary source. Mode bit 1 set selects the internal oscillator when the frequency field is non-zero or the source bit is set, and the slow RC clock otherwise. liveSrc reports the live source as 0 (slow RC), 1 (internal oscillator) or 2 (primary).
- R3: With the frequency field zero and the source bit clear, once settled, hfOscEn is 0 and intStable stays 0.
- R4: When the internal oscillator is requested, hfOscEn rises at once. intStable rises only after INT_STAB_CYCLES lfClk cycles, and until then the previous source stays live.
- R5: Returning to the internal oscillator while it is still enabled and already stable needs no new settling wait. The handover completes within 8 lfClk cycles, and intStable is 1 afterwards.
- R6: A switch to primary raises priOscEn. The switch waits for OST_CYCLES primary cycles, plus PLL_LOCK_CYCLES lfClk cycles when the PLL bit is set, and the old source stays live until then.
- R7: While the primary source is live, ostDone is 1 and intStable is 0. ostDone is 0 whenever another source is live.
- R8: The switching hardware never alters the stored mode field or idle bit; rdMode and rdIdle change only on writes.
- R9: lfRunEn is 1 unless the primary source is live with both wdtEn and fscmEn low.
- R10: At most one source is gated through at any time, and sysClk never shows a high or low phase shorter than the shortest half period of the sources.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| lfClk | input | 1 | Slow RC clock; also clocks the control logic |
| hfClk | input | 1 | Internal oscillator output |
| priClk | input | 1 | Primary oscillator (after optional PLL) |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Store the configuration word |
| wrMode | input | 2 | Run-mode field |
| wrFreq | input | FREQ_W | Internal-oscillator frequency field |
| wrIntSrc | input | 1 | Internal-source request bit |
| wrIdle | input | 1 | Idle-enable bit (stored only) |
| wrPll | input | 1 | PLL enable for the primary path |
| wdtEn | input | 1 | Watchdog enable, keeps slow RC running |
| fscmEn | input | 1 | Clock-monitor enable, keeps slow RC running |
| sysClk | output | 1 | Glitch-free system clock |
| liveSrc | output | 2 | Live source code |
| intStable | output | 1 | Internal oscillator stable flag |
| ostDone | output | 1 | Primary start-up complete, primary live |
| hfOscEn | output | 1 | Enable to the internal oscillator |
| priOscEn | output | 1 | Enable to the primary oscillator |
| lfRunEn | output | 1 | Enable to the slow RC clock |
| rdMode | output | 2 | Stored mode field |
| rdIdle | output | 1 | Stored idle bit |

## Verification
If a stability counter is set wrongly, liveSrc moves to the new source too early or too late. This shows at the ports within the settling window, and the bench samples both before and after the expected switch point. A gating flop that is set wrongly, or that changes on the wrong edge, shows within one source period as a short high or low phase on sysClk, or as two sources overlapping. A status flag computed wrongly is visible in the first settled sample after each switch.

// File: rtl/csw_pkg.sv
`timescale 1ns/1ps
package csw_pkg;
  localparam int NSRC = 3;
  localparam int SRC_LF  = 0;
  localparam int SRC_HF  = 1;
  localparam int SRC_PRI = 2;

  // control -> datapath strobes
  typedef struct packed {
    logic [NSRC-1:0] selOneHot;
    logic            priRun;
  } cswStrobe_t;
endpackage

// File: rtl/csw_ctrl.sv
`timescale 1ns/1ps
module csw_ctrl
  import csw_pkg::*;
#(
  parameter int FREQ_W          = 3,
  parameter int INT_STAB_CYCLES = 64,
  parameter int PLL_LOCK_CYCLES = 2000
) (
  input  logic              lfClk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        wrMode,
  input  logic [FREQ_W-1:0] wrFreq,
  input  logic              wrIntSrc,
  input  logic              wrIdle,
  input  logic              wrPll,
  input  logic              wdtEn,
  input  logic              fscmEn,
  input  logic [NSRC-1:0]   liveOneHot,
  input  logic              ostDonePri,
  output cswStrobe_t        strobe,
  output logic [1:0]        liveSrc,
  output logic              intStable,
  output logic              ostDone,
  output logic              hfOscEn,
  output logic              priOscEn,
  output logic              lfRunEn,
  output logic [1:0]        rdMode,
  output logic              rdIdle
);
  localparam int HW = $clog2(INT_STAB_CYCLES + 1);
  localparam int PW = $clog2(PLL_LOCK_CYCLES + 1);
  localparam logic [HW-1:0] HF_LAST  = HW'(INT_STAB_CYCLES);
  localparam logic [PW-1:0] PLL_LAST = PW'(PLL_LOCK_CYCLES);
  localparam logic [NSRC-1:0] ONE_LF = NSRC'(1) << SRC_LF;

  typedef enum logic {ST_RUN, ST_SWITCH} ctlState_e;

  logic [1:0]        modeQ;
  logic [FREQ_W-1:0] freqQ;
  logic              intSrcQ, idleQ, pllQ;
  logic              hfReq;
  logic [NSRC-1:0]   tgtOneHot, readyVec, selQ;
  logic [NSRC-1:0]   liveS1, liveS2;
  logic [HW-1:0]     hfCnt;
  logic [PW-1:0]     pllCnt;
  logic              hfStable, ostS1, ostS2, priReady, tgtReady;
  logic              priRunQ, hfRunQ;
  ctlState_e         stQ;

  // configuration word
  always_ff @(posedge lfClk or negedge rstN) begin
    if (!rstN) begin
      modeQ   <= '0;
      freqQ   <= '0;
      intSrcQ <= 1'b0;
      idleQ   <= 1'b0;
      pllQ    <= 1'b0;
    end else if (wrEn) begin
      modeQ   <= wrMode;
      freqQ   <= wrFreq;
      intSrcQ <= wrIntSrc;
      idleQ   <= wrIdle;
      pllQ    <= wrPll;
    end
  end

  assign hfReq = (freqQ != '0) | intSrcQ;

  // target source decode
  always_comb begin
    tgtOneHot = '0;
    if (!modeQ[1])  tgtOneHot[SRC_PRI] = 1'b1;
    else if (hfReq) tgtOneHot[SRC_HF]  = 1'b1;
    else            tgtOneHot[SRC_LF]  = 1'b1;
  end

  // internal oscillator settling counter
  always_ff @(posedge lfClk or negedge rstN) begin
    if (!rstN)                 hfCnt <= '0;
    else if (!hfReq)           hfCnt <= '0;
    else if (hfCnt != HF_LAST) hfCnt <= hfCnt + 1'b1;
  end
  assign hfStable = (hfCnt == HF_LAST);

  // primary start-up sync and PLL lock timer
  always_ff @(posedge lfClk or negedge rstN) begin
    if (!rstN) begin
      ostS1 <= 1'b0;
      ostS2 <= 1'b0;
    end else begin
      ostS1 <= ostDonePri;
      ostS2 <= ostS1;
    end
  end

  always_ff @(posedge lfClk or negedge rstN) begin
    if (!rstN)                   pllCnt <= '0;
    else if (!ostS2 || !pllQ)    pllCnt <= '0;
    else if (pllCnt != PLL_LAST) pllCnt <= pllCnt + 1'b1;
  end
  assign priReady = ostS2 & (~pllQ | (pllCnt == PLL_LAST));

  // live-source feedback from the gating flops
  always_ff @(posedge lfClk or negedge rstN) begin
    if (!rstN) begin
      liveS1 <= ONE_LF;
      liveS2 <= ONE_LF;
    end else begin
      liveS1 <= liveOneHot;
      liveS2 <= liveS1;
    end
  end

  always_comb begin
    readyVec          = '0;
    readyVec[SRC_LF]  = 1'b1;
    readyVec[SRC_HF]  = hfStable;
    readyVec[SRC_PRI] = priReady;
  end
  assign tgtReady = |(tgtOneHot & readyVec);

  // switch sequencer
  always_ff @(posedge lfClk or negedge rstN) begin
    if (!rstN) begin
      stQ  <= ST_RUN;
      selQ <= ONE_LF;
    end else begin
      unique case (stQ)
        ST_RUN: begin
          if (tgtOneHot != selQ && tgtReady) begin
            selQ <= tgtOneHot;
            stQ  <= ST_SWITCH;
          end
        end
        ST_SWITCH: begin
          if (liveS2 == selQ) stQ <= ST_RUN;
        end
        default: stQ <= ST_RUN;
      endcase
    end
  end

  // oscillator enables, registered so the primary reset is clean
  always_ff @(posedge lfClk or negedge rstN) begin
    if (!rstN) begin
      priRunQ <= 1'b0;
      hfRunQ  <= 1'b0;
    end else begin
      priRunQ <= tgtOneHot[SRC_PRI] | selQ[SRC_PRI] | liveS2[SRC_PRI];
      hfRunQ  <= selQ[SRC_HF] | liveS2[SRC_HF];
    end
  end

  assign strobe.selOneHot = selQ;
  assign strobe.priRun    = priRunQ;

  assign liveSrc   = liveS2[SRC_PRI] ? 2'd2 : (liveS2[SRC_HF] ? 2'd1 : 2'd0);
  assign ostDone   = liveS2[SRC_PRI];
  assign intStable = hfStable & ~liveS2[SRC_PRI];
  assign hfOscEn   = hfReq | hfRunQ;
  assign priOscEn  = priRunQ;
  assign lfRunEn   = ~liveS2[SRC_PRI] | wdtEn | fscmEn;
  assign rdMode    = modeQ;
  assign rdIdle    = idleQ;
endmodule

// File: rtl/csw_datapath.sv
`timescale 1ns/1ps
module csw_datapath
  import csw_pkg::*;
#(
  parameter int OST_CYCLES = 1024
) (
  input  logic            rstN,
  input  logic            lfClk,
  input  logic            hfClk,
  input  logic            priClk,
  input  cswStrobe_t      strobe,
  output logic            sysClk,
  output logic [NSRC-1:0] liveOneHot,
  output logic            ostDonePri
);
  localparam int OW = $clog2(OST_CYCLES + 1);
  localparam logic [OW-1:0] OST_LAST = OW'(OST_CYCLES);

  logic [NSRC-1:0] srcClk;
  logic [NSRC-1:0] enQ;
  logic [OW-1:0]   ostCnt;
  logic            priRstN;

  assign srcClk = {priClk, hfClk, lfClk};

  // one gating branch per source: two falling-edge flops, enabled only
  // after every other branch has been seen off
  for (genvar i = 0; i < NSRC; i++) begin : g_branch
    localparam logic [NSRC-1:0] OTHERS = ~(NSRC'(1) << i);
    localparam logic RST_ON = (i == SRC_LF);
    logic want, s1, s2;
    assign want = strobe.selOneHot[i] & ~|(enQ & OTHERS);
    always_ff @(negedge srcClk[i] or negedge rstN) begin
      if (!rstN) begin
        s1 <= RST_ON;
        s2 <= RST_ON;
      end else begin
        s1 <= want;
        s2 <= s1;
      end
    end
    assign enQ[i] = s2;
  end

  assign sysClk     = |(srcClk & enQ);
  assign liveOneHot = enQ;

  // primary start-up counter in the primary domain
  assign priRstN = rstN & strobe.priRun;
  always_ff @(posedge priClk or negedge priRstN) begin
    if (!priRstN)               ostCnt <= '0;
    else if (ostCnt != OST_LAST) ostCnt <= ostCnt + 1'b1;
  end
  assign ostDonePri = (ostCnt == OST_LAST);
endmodule

// File: rtl/clk_src_switch.sv
`timescale 1ns/1ps
module clk_src_switch
  import csw_pkg::*;
#(
  parameter int FREQ_W          = 3,
  parameter int OST_CYCLES      = 1024,
  parameter int PLL_LOCK_CYCLES = 2000,
  parameter int INT_STAB_CYCLES = 64
) (
  input  logic              lfClk,
  input  logic              hfClk,
  input  logic              priClk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        wrMode,
  input  logic [FREQ_W-1:0] wrFreq,
  input  logic              wrIntSrc,
  input  logic              wrIdle,
  input  logic              wrPll,
  input  logic              wdtEn,
  input  logic              fscmEn,
  output logic              sysClk,
  output logic [1:0]        liveSrc,
  output logic              intStable,
  output logic              ostDone,
  output logic              hfOscEn,
  output logic              priOscEn,
  output logic              lfRunEn,
  output logic [1:0]        rdMode,
  output logic              rdIdle
);
  cswStrobe_t      strobe;
  logic [NSRC-1:0] liveOneHot;
  logic            ostDonePri;

  csw_ctrl #(
    .FREQ_W(FREQ_W),
    .INT_STAB_CYCLES(INT_STAB_CYCLES),
    .PLL_LOCK_CYCLES(PLL_LOCK_CYCLES)
  ) u_ctrl (
    .lfClk(lfClk), .rstN(rstN),
    .wrEn(wrEn), .wrMode(wrMode), .wrFreq(wrFreq), .wrIntSrc(wrIntSrc),
    .wrIdle(wrIdle), .wrPll(wrPll), .wdtEn(wdtEn), .fscmEn(fscmEn),
    .liveOneHot(liveOneHot), .ostDonePri(ostDonePri), .strobe(strobe),
    .liveSrc(liveSrc), .intStable(intStable), .ostDone(ostDone),
    .hfOscEn(hfOscEn), .priOscEn(priOscEn), .lfRunEn(lfRunEn),
    .rdMode(rdMode), .rdIdle(rdIdle)
  );

  csw_datapath #(.OST_CYCLES(OST_CYCLES)) u_dp (
    .rstN(rstN), .lfClk(lfClk), .hfClk(hfClk), .priClk(priClk),
    .strobe(strobe), .sysClk(sysClk), .liveOneHot(liveOneHot),
    .ostDonePri(ostDonePri)
  );
endmodule

// File: rtl/csw_checker.sv
`timescale 1ns/1ps
module csw_checker (
  input logic       lfClk,
  input logic       rstN,
  input logic       wrEn,
  input logic [1:0] rdMode,
  input logic       rdIdle,
  input logic       hfOscEn,
  input logic       intStable,
  input logic       ostDone,
  input logic       lfRunEn,
  input logic [2:0] liveOneHot,
  input logic       ostDonePri
);
  // R10: never two sources gated through together
  p_one_source_r10: assert property (@(posedge lfClk) disable iff (!rstN)
    $onehot0(liveOneHot));

  // R3: internal oscillator off for two samples means no stable flag
  p_no_stable_r3: assert property (@(posedge lfClk) disable iff (!rstN)
    (!hfOscEn && !$past(hfOscEn)) |-> !intStable);

  // R6: primary only goes live after its start-up count finished
  p_pri_wait_r6: assert property (@(posedge lfClk) disable iff (!rstN)
    $rose(ostDone) |-> ostDonePri);

  // R7: both flags never set together
  p_flags_excl_r7: assert property (@(posedge lfClk) disable iff (!rstN)
    ostDone |-> !intStable);

  // R8: stored mode and idle bit only move on a write
  p_cfg_hold_r8: assert property (@(posedge lfClk) disable iff (!rstN)
    !wrEn |=> ($stable(rdMode) && $stable(rdIdle)));

  // R9: slow RC runs whenever primary is not live
  p_lf_run_r9: assert property (@(posedge lfClk) disable iff (!rstN)
    !ostDone |-> lfRunEn);
endmodule

bind clk_src_switch csw_checker u_chk (
  .lfClk(lfClk), .rstN(rstN), .wrEn(wrEn), .rdMode(rdMode), .rdIdle(rdIdle),
  .hfOscEn(hfOscEn), .intStable(intStable), .ostDone(ostDone),
  .lfRunEn(lfRunEn), .liveOneHot(liveOneHot), .ostDonePri(ostDonePri)
);

// File: tb/tb_clk_src_switch.sv
`timescale 1ns/1ps
module tb_clk_src_switch;
  localparam real CLK_PERIOD = 40.0;  // lfClk
  localparam real HF_PERIOD  = 14.0;
  localparam real PRI_PERIOD = 10.0;
  localparam real MIN_PHASE  = 4.5;
  localparam int  OST        = 1024;
  localparam int  PLLC       = 32;
  localparam int  STAB       = 16;

  logic lfClk = 0, hfClk = 0, priClk = 0;
  logic rstN = 0, wrEn = 0, wrIntSrc = 0, wrIdle = 0, wrPll = 0;
  logic wdtEn = 0, fscmEn = 0;
  logic [1:0] wrMode = '0;
  logic [2:0] wrFreq = '0;
  logic sysClk, intStable, ostDone, hfOscEn, priOscEn, lfRunEn, rdIdle;
  logic [1:0] liveSrc, rdMode;

  int total = 0, bad = 0, shortPhase = 0, sysEdges = 0;
  bit done = 0;
  realtime lastEdge = 0.0;

  always #(CLK_PERIOD / 2.0) lfClk = ~lfClk;
  always #(HF_PERIOD / 2.0)  hfClk = ~hfClk;
  always #(PRI_PERIOD / 2.0) priClk = ~priClk;

  clk_src_switch #(
    .FREQ_W(3), .OST_CYCLES(OST), .PLL_LOCK_CYCLES(PLLC), .INT_STAB_CYCLES(STAB)
  ) dut (
    .lfClk(lfClk), .hfClk(hfClk), .priClk(priClk), .rstN(rstN),
    .wrEn(wrEn), .wrMode(wrMode), .wrFreq(wrFreq), .wrIntSrc(wrIntSrc),
    .wrIdle(wrIdle), .wrPll(wrPll), .wdtEn(wdtEn), .fscmEn(fscmEn),
    .sysClk(sysClk), .liveSrc(liveSrc), .intStable(intStable),
    .ostDone(ostDone), .hfOscEn(hfOscEn), .priOscEn(priOscEn),
    .lfRunEn(lfRunEn), .rdMode(rdMode), .rdIdle(rdIdle)
  );

  // R10 monitor: every sysClk phase must last at least a source half period
  always @(sysClk) begin
    if (rstN && ($realtime - lastEdge) < MIN_PHASE) shortPhase++;
    lastEdge = $realtime;
    sysEdges++;
  end

  function automatic int expSrc(logic [1:0] m, logic [2:0] f, logic s);
    if (!m[1]) return 2;
    return ((f != 0) || s) ? 1 : 0;
  endfunction

  function automatic int expIntStable(logic [1:0] m, logic [2:0] f, logic s);
    return (expSrc(m, f, s) == 1) ? 1 : 0;
  endfunction

  task automatic check(string req, int actual, int expected);
    total++;
    if (actual != expected) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, actual, expected, $time);
    end
  endtask

  task automatic waitCyc(int n);
    repeat (n) @(negedge lfClk);
  endtask

  task automatic writeCfg(logic [1:0] m, logic [2:0] f, logic s, logic idle, logic pll);
    @(negedge lfClk);
    wrEn = 1; wrMode = m; wrFreq = f; wrIntSrc = s; wrIdle = idle; wrPll = pll;
    @(negedge lfClk);
    wrEn = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000.0);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    waitCyc(5);
    rstN = 1;
    waitCyc(2);
    // R1 reset state (mode 00 targets primary, slow RC still live)
    check("R1 liveSrc", liveSrc, 0);
    check("R1 intStable", intStable, 0);
    check("R1 ostDone", ostDone, 0);
    check("R1 rdMode", rdMode, 0);
    check("R1 rdIdle", rdIdle, 0);
    check("R6 priOscEn", priOscEn, 1);
    waitCyc(190);
    check("R6 still on slow RC during start-up", liveSrc, 0);
    check("R6 ostDone low during start-up", ostDone, 0);
    waitCyc(110);
    check("R6 primary live", liveSrc, 2);
    check("R7 ostDone", ostDone, 1);
    check("R7 intStable", intStable, 0);
    check("R9 lfRunEn off", lfRunEn, 0);
    wdtEn = 1; waitCyc(1);
    check("R9 lfRunEn wdt", lfRunEn, 1);
    wdtEn = 0; fscmEn = 1; waitCyc(1);
    check("R9 lfRunEn fscm", lfRunEn, 1);
    fscmEn = 0;

    // R3 internal block with oscillator off -> slow RC
    writeCfg(2'b10, 3'd0, 1'b0, 1'b1, 1'b0);
    waitCyc(15);
    check("R3 liveSrc", liveSrc, 0);
    check("R3 hfOscEn", hfOscEn, 0);
    check("R3 intStable", intStable, 0);
    check("R7 ostDone off", ostDone, 0);
    check("R6 priOscEn off", priOscEn, 0);
    check("R8 rdMode", rdMode, 2);
    check("R8 rdIdle", rdIdle, 1);

    // R4 enable internal oscillator
    writeCfg(2'b11, 3'd5, 1'b0, 1'b1, 1'b0);
    waitCyc(5);
    check("R4 hfOscEn", hfOscEn, 1);
    check("R4 intStable early", intStable, 0);
    check("R4 old source kept", liveSrc, 0);
    waitCyc(30);
    check("R4 intStable", intStable, 1);
    check("R4 liveSrc", liveSrc, 1);

    // R6 primary with PLL
    writeCfg(2'b01, 3'd5, 1'b0, 1'b1, 1'b1);
    waitCyc(200);
    check("R6 hf kept during start-up", liveSrc, 1);
    waitCyc(80);
    check("R6 hf kept during PLL lock", liveSrc, 1);
    waitCyc(50);
    check("R6 primary live with PLL", liveSrc, 2);
    check("R7 ostDone", ostDone, 1);
    check("R7 intStable cleared", intStable, 0);
    check("R8 rdMode untouched", rdMode, 1);
    check("R8 rdIdle untouched", rdIdle, 1);

    // R5 return to already-stable internal oscillator
    writeCfg(2'b10, 3'd5, 1'b0, 1'b0, 1'b0);
    waitCyc(8);
    check("R5 liveSrc", liveSrc, 1);
    check("R5 intStable", intStable, 1);
    check("R7 ostDone", ostDone, 0);

    // R2 constrained random configurations
    for (int k = 0; k < 10; k++) begin
      logic [1:0] m;
      logic [2:0] f;
      logic s, idle, pll;
      m    = 2'($urandom % 4);
      f    = ($urandom % 2) ? 3'd0 : 3'($urandom % 8);
      s    = ($urandom % 4) == 0;
      idle = 1'($urandom % 2);
      pll  = 1'($urandom % 2);
      writeCfg(m, f, s, idle, pll);
      waitCyc(400);
      check("R2 liveSrc", liveSrc, expSrc(m, f, s));
      check("R7 ostDone", ostDone, (expSrc(m, f, s) == 2) ? 1 : 0);
      check("R4 intStable", intStable, expIntStable(m, f, s));
      check("R8 rdIdle", rdIdle, idle);
    end

    check("R10 short sysClk phases", shortPhase, 0);
    check("R10 sysClk toggling", (sysEdges > 100) ? 1 : 0, 1);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule